// File: doc/BRIEF.md
# Gated Phase-Error Frequency Feedback

This block builds the signed frequency word for a direct digital synthesizer once per update tick. The word is the current frequency-curve value plus a feedback term. The feedback term is the phase error, clamped to a fixed magnitude, multiplied by a signed gain and arithmetically shifted right. A beam-gate input switches the feedback term on and off. That input arrives asynchronously, so it passes through a two-flop synchronizer. The synchronized gate, the clamped error, the gain and the curve value are then frozen together on the accepted update pulse. Nothing that changes during a calculation can corrupt the result.

A small state machine steps through four states. `FF_WAIT` idles until an update pulse arrives, then captures the operands; this is transition T_ACCEPT. `FF_MUL` forms the product; its exit is T_PRODUCT. `FF_ADD` adds the shifted product to the curve value and saturates the sum; its exit is T_SUM. `FF_PUB` loads the output registers, raises the valid flag and the synthesizer update strobe for one cycle, and returns to `FF_WAIT` through T_PUBLISH. Alongside the word, the block drives a 16-bit offset-binary code for a bipolar DAC.

Top module: `ff_freq_feedback`

## Requirements
- R1: While rst_n is low and after it rises, freq_word is 0, dac_code is 16'h8000, and word_valid and dds_strobe are 0 until the first accepted pulse completes.
- R2: beam_gate passes through two clock flops before it is captured, so a change of beam_gate in the cycle of an update pulse does not affect that pulse's word.
- R3: When the captured gate is 0, the feedback term is zero and freq_word equals the captured curve_word.
- R4: phase_err, a 16-bit two's-complement value, is clamped to the range -ERR_LIMIT to +ERR_LIMIT (default 8192) before it is multiplied.
- R5: freq_word = curve_word + ((clamped error × err_gain) >>> PROD_SHIFT), where PROD_SHIFT defaults to 4, the shift is arithmetic and all operands are two's complement. The operands are those present at the clock edge that accepts the pulse; later input changes have no effect.
- R6: The 33-bit sum saturates to 32'h7FFFFFFF on positive overflow and to 32'h80000000 on negative overflow, and never wraps.
- R7: word_valid and dds_strobe are high together for exactly one cycle, 4 rising edges after the edge that samples upd_pulse high. Every accepted pulse produces one strobe.
- R8: An update pulse that arrives while a calculation is in progress (states FF_MUL, FF_ADD, FF_PUB) is ignored and produces no extra strobe or word.
- R9: freq_word and dac_code change only when word_valid is high. dac_code equals freq_word >>> 16, saturated to 16 signed bits, with bit 15 inverted, so dac_code[15] is always the inverse of freq_word[31].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_pulse | input | 1 | One-cycle update tick |
| beam_gate | input | 1 | Asynchronous feedback enable |
| curve_word | input | 32 | Signed frequency-curve value |
| phase_err | input | 16 | Signed phase error |
| err_gain | input | 16 | Signed feedback gain |
| freq_word | output | 32 | Signed frequency word to the synthesizer |
| word_valid | output | 1 | New word present this cycle |
| dds_strobe | output | 1 | Synthesizer update strobe |
| dac_code | output | 16 | Offset-binary DAC code of the word |

## Verification
The checker watches properties that hold on every cycle. It confirms that valid lasts one cycle and appears four edges after a pulse, that the strobe coincides with valid, that the word stays unchanged between publishes, and that the DAC sign bit mirrors the word's sign. The arithmetic needs the bench's scenarios: the clamp, the gain product, the shift rounding and both saturation limits. So do the gate's synchronizer delay, the freezing of operands during a calculation and the dropping of pulses that arrive while busy. All of these depend on chosen input values and timing.

// File: rtl/ff_feedback_pkg.sv
package ff_feedback_pkg;
    typedef enum logic [1:0] {
        FF_WAIT = 2'd0,
        FF_MUL  = 2'd1,
        FF_ADD  = 2'd2,
        FF_PUB  = 2'd3
    } ff_state_t;
endpackage

// File: rtl/ff_gate_sync.sv
module ff_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[i] <= 1'b0;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ff_err_trim.sv
module ff_err_trim #(
    parameter int EW    = 16,
    parameter int LIMIT = 8192
) (
    input  logic signed [EW-1:0] err_in,
    output logic signed [EW-1:0] err_out
);
    localparam logic signed [EW-1:0] HI = LIMIT[EW-1:0];
    localparam logic signed [EW-1:0] LO = -HI;

    always_comb begin
        if (err_in > HI)      err_out = HI;
        else if (err_in < LO) err_out = LO;
        else                  err_out = err_in;
    end
endmodule

// File: rtl/ff_dac_map.sv
module ff_dac_map #(
    parameter int FW    = 32,
    parameter int DW    = 16,
    parameter int SHIFT = 16
) (
    input  logic signed [FW-1:0] word_in,
    output logic        [DW-1:0] code_out
);
    localparam logic signed [FW-1:0] MAXV = FW'((64'sd1 <<< (DW-1)) - 64'sd1);
    localparam logic signed [FW-1:0] MINV = -MAXV - FW'(1);

    logic signed [FW-1:0] scaled;
    logic signed [DW-1:0] clipped;

    always_comb begin
        scaled = word_in >>> SHIFT;
        if (scaled > MAXV)      clipped = MAXV[DW-1:0];
        else if (scaled < MINV) clipped = MINV[DW-1:0];
        else                    clipped = scaled[DW-1:0];
        code_out = {~clipped[DW-1], clipped[DW-2:0]};
    end
endmodule

// File: rtl/ff_freq_feedback.sv
module ff_freq_feedback
    import ff_feedback_pkg::*;
#(
    parameter int FW          = 32,
    parameter int EW          = 16,
    parameter int GW          = 16,
    parameter int DW          = 16,
    parameter int PROD_SHIFT  = 4,
    parameter int ERR_LIMIT   = 8192,
    parameter int DAC_SHIFT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd_pulse,
    input  logic          beam_gate,
    input  logic [31:0]   curve_word,
    input  logic [15:0]   phase_err,
    input  logic [15:0]   err_gain,
    output logic [31:0]   freq_word,
    output logic          word_valid,
    output logic          dds_strobe,
    output logic [15:0]   dac_code
);
    localparam int PW = EW + GW;
    localparam int SW = FW + 1;
    localparam logic signed [FW-1:0] POS_MAX = {1'b0, {(FW-1){1'b1}}};
    localparam logic signed [FW-1:0] NEG_MAX = {1'b1, {(FW-1){1'b0}}};

    ff_state_t state_q, state_d;

    logic                 gate_sync;
    logic signed [EW-1:0] err_trim;
    logic signed [EW-1:0] err_q;
    logic signed [GW-1:0] gain_q;
    logic signed [FW-1:0] curve_q;
    logic signed [PW-1:0] prod_q;
    logic signed [PW-1:0] prod_sh;
    logic signed [SW-1:0] sum_ext;
    logic signed [FW-1:0] sum_q;
    logic signed [FW-1:0] sum_sat;
    logic        [DW-1:0] dac_next;

    ff_gate_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (beam_gate),
        .sync_out (gate_sync)
    );

    ff_err_trim #(.EW(EW), .LIMIT(ERR_LIMIT)) i_trim (
        .err_in  (phase_err),
        .err_out (err_trim)
    );

    ff_dac_map #(.FW(FW), .DW(DW), .SHIFT(DAC_SHIFT)) i_dac (
        .word_in  (sum_q),
        .code_out (dac_next)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FF_WAIT;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FF_WAIT: if (upd_pulse) state_d = FF_MUL;  // T_ACCEPT
            FF_MUL:  state_d = FF_ADD;                  // T_PRODUCT
            FF_ADD:  state_d = FF_PUB;                  // T_SUM
            FF_PUB:  state_d = FF_WAIT;                 // T_PUBLISH
        endcase
    end

    // saturating adder
    always_comb begin
        prod_sh = prod_q >>> PROD_SHIFT;
        sum_ext = {curve_q[FW-1], curve_q}
                + {{(SW-PW){prod_sh[PW-1]}}, prod_sh};
        if (sum_ext[SW-1] != sum_ext[SW-2])
            sum_sat = sum_ext[SW-1] ? NEG_MAX : POS_MAX;
        else
            sum_sat = sum_ext[FW-1:0];
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q      <= '0;
            gain_q     <= '0;
            curve_q    <= '0;
            prod_q     <= '0;
            sum_q      <= '0;
            freq_word  <= '0;
            dac_code   <= {1'b1, {(DW-1){1'b0}}};
            word_valid <= 1'b0;
            dds_strobe <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            dds_strobe <= 1'b0;
            unique case (state_q)
                FF_WAIT: begin
                    if (upd_pulse) begin
                        err_q   <= gate_sync ? err_trim : '0;
                        gain_q  <= err_gain;
                        curve_q <= curve_word;
                    end
                end
                FF_MUL: prod_q <= err_q * gain_q;
                FF_ADD: sum_q  <= sum_sat;
                FF_PUB: begin
                    freq_word  <= sum_q;
                    dac_code   <= dac_next;
                    word_valid <= 1'b1;
                    dds_strobe <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ff_freq_feedback_chk.sv
module ff_freq_feedback_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        upd_pulse,
    input logic [31:0] freq_word,
    input logic        word_valid,
    input logic        dds_strobe,
    input logic [15:0] dac_code
);
    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid);

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(word_valid) |-> $past(upd_pulse, 4));

    // R7
    strobe_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dds_strobe == word_valid);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !word_valid |-> ($stable(freq_word) && $stable(dac_code)));

    // R9
    dac_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dac_code[15] == ~freq_word[31]);
endmodule

bind ff_freq_feedback ff_freq_feedback_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_pulse  (upd_pulse),
    .freq_word  (freq_word),
    .word_valid (word_valid),
    .dds_strobe (dds_strobe),
    .dac_code   (dac_code)
);

// File: tb/test_ff_freq_feedback.sv
module test_ff_freq_feedback;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_pulse = 1'b0;
    logic        beam_gate = 1'b0;
    logic [31:0] curve_word = '0;
    logic [15:0] phase_err = '0;
    logic [15:0] err_gain = '0;
    logic [31:0] freq_word;
    logic        word_valid;
    logic        dds_strobe;
    logic [15:0] dac_code;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ff_freq_feedback i_ff_freq_feedback (
        .clk(clk), .rst_n(rst_n), .upd_pulse(upd_pulse), .beam_gate(beam_gate),
        .curve_word(curve_word), .phase_err(phase_err), .err_gain(err_gain),
        .freq_word(freq_word), .word_valid(word_valid), .dds_strobe(dds_strobe),
        .dac_code(dac_code)
    );

    // {gate, curve, err, gain}
    localparam int NV = 8;
    localparam logic [64:0] VEC [NV] = '{
        {1'b1, 32'h1000_0000, 16'h0064, 16'h0100},  // R5 positive
        {1'b1, 32'h1000_0000, 16'hFF9C, 16'h0100},  // R5 negative error
        {1'b1, 32'h2000_0000, 16'h4E20, 16'h03E8},  // R4 clamp high
        {1'b1, 32'h0000_0000, 16'h8AD0, 16'h8000},  // R4 clamp low, neg gain
        {1'b0, 32'h0ABC_DEF0, 16'h01F4, 16'h01F4},  // R3 gate off
        {1'b1, 32'h7FFF_FFF0, 16'h2000, 16'h7FFF},  // R6 saturate high
        {1'b1, 32'h8000_0010, 16'h2000, 16'h8000},  // R6 saturate low
        {1'b1, 32'h0000_0005, 16'hFFFF, 16'h0001}   // R5 arithmetic shift
    };

    function automatic logic [31:0] model_word(bit g, logic [31:0] c,
                                               logic [15:0] e, logic [15:0] k);
        longint ev = longint'(signed'(e));
        longint p;
        longint s;
        if (ev > 8192) ev = 8192;
        if (ev < -8192) ev = -8192;
        if (!g) ev = 0;
        p = (ev * longint'(signed'(k))) >>> 4;
        s = longint'(signed'(c)) + p;
        if (s > 64'sh7FFF_FFFF) s = 64'sh7FFF_FFFF;
        if (s < -64'sh8000_0000) s = -64'sh8000_0000;
        return s[31:0];
    endfunction

    function automatic logic [15:0] model_dac(logic [31:0] w);
        longint v = longint'(signed'(w)) >>> 16;
        if (v > 32767) v = 32767;
        if (v < -32768) v = -32768;
        return {~v[15], v[14:0]};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // pulse at a negedge; returns at the negedge after the result appears
    task automatic pulse_and_check(string req, logic [31:0] exp_w);
        upd_pulse = 1'b1;
        @(negedge clk);
        upd_pulse = 1'b0;
        repeat (2) @(negedge clk);
        check({req, " R7 early"}, {31'd0, word_valid}, 32'd0);
        @(negedge clk);
        check({req, " R7 valid"}, {31'd0, word_valid}, 32'd1);
        check({req, " R7 strobe"}, {31'd0, dds_strobe}, 32'd1);
        check({req, " word"}, freq_word, exp_w);
        check({req, " R9 dac"}, {16'd0, dac_code}, {16'd0, model_dac(exp_w)});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 word", freq_word, 32'd0);
        check("R1 dac", {16'd0, dac_code}, 32'h0000_8000);
        check("R1 valid", {31'd0, word_valid}, 32'd0);
        check("R1 strobe", {31'd0, dds_strobe}, 32'd0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 idle after release", {31'd0, word_valid}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            beam_gate  = VEC[i][64];
            curve_word = VEC[i][63:32];
            phase_err  = VEC[i][31:16];
            err_gain   = VEC[i][15:0];
            repeat (4) @(negedge clk);
            pulse_and_check("R5 vector", model_word(VEC[i][64], VEC[i][63:32],
                                                    VEC[i][31:16], VEC[i][15:0]));
        end

        // R2: gate rises in the same cycle as the pulse -> not yet seen
        beam_gate = 1'b0;
        curve_word = 32'h0100_0000; phase_err = 16'h0064; err_gain = 16'h0100;
        repeat (4) @(negedge clk);
        beam_gate = 1'b1;
        pulse_and_check("R2 rise late", 32'h0100_0000);
        repeat (2) @(negedge clk);
        pulse_and_check("R2 rise seen", 32'h0100_0640);
        // R2: gate falls with the pulse -> feedback still applied
        beam_gate = 1'b0;
        pulse_and_check("R2 fall late", 32'h0100_0640);
        repeat (2) @(negedge clk);
        pulse_and_check("R3 fall seen", 32'h0100_0000);

        // R5 + R8: inputs change and a second pulse arrives while busy
        beam_gate = 1'b1;
        repeat (4) @(negedge clk);
        curve_word = 32'h0000_1000; phase_err = 16'h0010; err_gain = 16'h0010;
        upd_pulse = 1'b1;
        @(negedge clk);
        curve_word = 32'h5555_0000; phase_err = 16'h1000; err_gain = 16'h1000;
        @(negedge clk);
        upd_pulse = 1'b0;
        @(negedge clk);
        check("R8 no early valid", {31'd0, word_valid}, 32'd0);
        @(negedge clk);
        check("R7 busy valid", {31'd0, word_valid}, 32'd1);
        check("R5 frozen operands", freq_word, 32'h0000_1010);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            check("R8 dropped pulse", {31'd0, dds_strobe}, 32'd0);
        end
        check("R9 word held", freq_word, 32'h0000_1010);

        // R1: reset in mid-operation clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset word", freq_word, 32'd0);
        check("R1 mid reset dac", {16'd0, dac_code}, 32'h0000_8000);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule